// File: doc/BRIEF.md
# Packed Lane Constant-Divisor Divider

This block divides every lane of a 128-bit packed word by one shared positive divisor. It does not iterate. The divisor arrives already reduced to a multiplier and two shift counts, all computed outside the block. Each lane then takes the high half of a multiply, applies a small add or subtract fix-up, and shifts the result. The quotient is truncated toward zero.

A parameter sets the lane width: 16 bits gives eight lanes, and 32 bits gives four lanes. A per-transaction mode bit chooses between signed and unsigned lanes. The multiplier and shift counts are captured together with the dividend, so every transaction can carry a different divisor and mode.

The input and output sides each have a valid/ready handshake. Inside sit two register stages: one holds the multiplier products and one holds the quotients. Divisors must be positive. A negative divisor is handled outside the block, by negating it before the parameters are formed and negating the result afterwards.

Top module: `packed_const_divider`

## Requirements
- R1: In unsigned mode (`in_signed`=0), the divisor d has L = ceil(log2 d), the multiplier is `in_mult` = (1 + 2^n·(2^L−d)/d) mod 2^n, `in_pre_shift` = min(L,1) and `in_post_shift` = max(L−1,0). With those inputs every n-bit lane returns floor(x/d) as an unsigned value.
- R2: In signed mode (`in_signed`=1), the divisor d (1 ≤ d < 2^(n−1)) has L = max(ceil(log2 d),1), the multiplier is `in_mult` = (1 + 2^(n+L−1)/d − 2^n) mod 2^n and `in_post_shift` = L−1. `in_pre_shift` has no effect in this mode. Every lane returns x/d in two's complement, truncated toward zero.
- R3: Lane i occupies bits [i·n +: n] of both `in_dividend` and `out_quotient`. Each lane's quotient depends only on its own dividend bits and the shared parameters. No carry or shift crosses a lane boundary.
- R4: With d = 1, the output equals the dividend in both modes, including the extremes 0, the most negative value and all ones.
- R5: The mode bit, multiplier and shifts are sampled together with the dividend. Back-to-back transactions with different modes and divisors each get their own result.
- R6: Suppose the input is accepted at rising edge k and `out_ready` is high. Then `out_valid` is low after edge k and high after edge k+1, carrying that transaction's quotient.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_quotient` stay unchanged.
- R8: `in_ready` is low only when both stages are full and `out_ready` is low. Results leave in acceptance order, with no loss and no duplication.
- R9: While `rst_n` is low, `out_valid` is low. After reset, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Dividend and parameters are present |
| in_ready | output | 1 | Block accepts the input this cycle |
| in_signed | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| in_dividend | input | WORD_W | Packed dividend lanes |
| in_mult | input | LANE_W | Shared multiplier |
| in_pre_shift | input | $clog2(LANE_W) | Shift applied after the difference (unsigned mode only) |
| in_post_shift | input | $clog2(LANE_W) | Final right shift |
| out_valid | output | 1 | Quotient is present |
| out_ready | input | 1 | Consumer takes the quotient |
| out_quotient | output | WORD_W | Packed quotient lanes |

## Verification
Two things can happen in the same cycle. A finished quotient can be handed to a stalled consumer while a new dividend, with a different mode and divisor, is entering the first stage. The bench provokes this by toggling `in_valid` and `out_ready` at random on every cycle during a long mixed-mode stream. It judges the result in two ways. First, it compares each delivered word against a queue of quotients computed by plain integer division in acceptance order. Second, it checks that every stalled output word is held unchanged until the consumer takes it.

// File: rtl/packed_const_divider.sv
module packed_const_divider #(
  parameter int LANE_W = 16,
  parameter int WORD_W = 128,
  localparam int SH_W = $clog2(LANE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_signed,
  input  logic [WORD_W-1:0] in_dividend,
  input  logic [LANE_W-1:0] in_mult,
  input  logic [SH_W-1:0]   in_pre_shift,
  input  logic [SH_W-1:0]   in_post_shift,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_quotient
);
  localparam int LANES = WORD_W / LANE_W;
  localparam int PW = 2 * LANE_W;

  logic              s1_v;
  logic              s1_sgn;
  logic [SH_W-1:0]   s1_pre, s1_post;
  logic [WORD_W-1:0] s1_x, s1_hi;
  logic [WORD_W-1:0] hi_next, q_next;

  wire s2_en = out_ready || !out_valid;
  wire s1_en = s2_en || !s1_v;
  assign in_ready = s1_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wire [LANE_W-1:0] x  = in_dividend[g*LANE_W +: LANE_W];
    wire [PW-1:0]     xe = {{(PW-LANE_W){in_signed & x[LANE_W-1]}}, x};
    wire [PW-1:0]     me = {{(PW-LANE_W){in_signed & in_mult[LANE_W-1]}}, in_mult};
    wire [PW-1:0]     prod = xe * me;
    assign hi_next[g*LANE_W +: LANE_W] = LANE_W'(prod >> LANE_W);

    wire [LANE_W-1:0] xs = s1_x[g*LANE_W +: LANE_W];
    wire [LANE_W-1:0] ts = s1_hi[g*LANE_W +: LANE_W];
    wire [LANE_W-1:0] u_diff = (xs - ts) >> s1_pre;
    wire [LANE_W-1:0] u_q = (u_diff + ts) >> s1_post;
    wire [LANE_W-1:0] s_sum = xs + ts;
    wire signed [LANE_W-1:0] s_sh = $signed(s_sum) >>> s1_post;
    wire [LANE_W-1:0] s_q = $unsigned(s_sh) + {{(LANE_W-1){1'b0}}, xs[LANE_W-1]};
    assign q_next[g*LANE_W +: LANE_W] = s1_sgn ? s_q : u_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_sgn  <= 1'b0;
      s1_pre  <= '0;
      s1_post <= '0;
      s1_x    <= '0;
      s1_hi   <= '0;
    end else if (s1_en) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_sgn  <= in_signed;
        s1_pre  <= in_pre_shift;
        s1_post <= in_post_shift;
        s1_x    <= in_dividend;
        s1_hi   <= hi_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_quotient <= '0;
    end else if (s2_en) begin
      out_valid <= s1_v;
      if (s1_v) out_quotient <= q_next;
    end
  end
endmodule

module packed_const_divider_chk #(
  parameter int LANE_W = 16,
  parameter int WORD_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_quotient,
  input logic              s1_v
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_quotient));

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> s1_v && out_valid && !out_ready);

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !s1_v |=> !out_valid);

  p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_v);

  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && (out_ready || !out_valid) |=> out_valid);

  always @(posedge clk)
    if (!rst_n) p_reset_r9: assert (!out_valid && !s1_v);
endmodule

bind packed_const_divider packed_const_divider_chk #(.LANE_W(LANE_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/test_packed_const_divider.sv
module test_packed_const_divider;
  localparam int LW = 16;
  localparam int WW = 128;
  localparam int NL = WW / LW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_signed = 0, out_ready = 0;
  logic [WW-1:0] in_dividend = '0;
  logic [LW-1:0] in_mult = '0;
  logic [3:0] in_pre_shift = '0, in_post_shift = '0;
  logic in_ready, out_valid;
  logic [WW-1:0] out_quotient;

  always #4 clk = ~clk;

  packed_const_divider #(.LANE_W(LW), .WORD_W(WW)) i_packed_const_divider (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  logic [WW-1:0] exp_q[$];
  string tag_q[$];
  bit hold_pend = 0;
  logic [WW-1:0] hold_q;

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void params(input bit sg, input int d, output logic [LW-1:0] m,
                                 output int pre, output int post);
    int L = 0;
    longint mm;
    while ((1 << L) < d) L++;
    if (sg) begin
      if (L < 1) L = 1;
      mm = 1 + (longint'(1) << (LW + L - 1)) / d - (longint'(1) << LW);
      pre = 0;
      post = L - 1;
    end else begin
      mm = 1 + ((longint'(1) << LW) * ((longint'(1) << L) - d)) / d;
      pre = (L > 0) ? 1 : 0;
      post = (L > 0) ? L - 1 : 0;
    end
    m = LW'(mm);
  endfunction

  function automatic logic [WW-1:0] expect_word(input logic [WW-1:0] x, input bit sg, input int d);
    logic [WW-1:0] r;
    for (int i = 0; i < NL; i++) begin
      longint xv, q;
      if (sg) xv = longint'($signed(x[i*LW +: LW]));
      else    xv = longint'(x[i*LW +: LW]);
      q = xv / d;
      r[i*LW +: LW] = LW'(q);
    end
    return r;
  endfunction

  task automatic step(input logic v, input logic [WW-1:0] x, input bit sg, input int d,
                      input logic ordy, input string tag, output bit acc, output bit ov);
    logic [LW-1:0] m;
    int pre, post;
    logic [WW-1:0] e;
    string t;
    params(sg, (d < 1) ? 1 : d, m, pre, post);
    @(negedge clk);
    in_valid = v; in_dividend = x; in_signed = sg; in_mult = m;
    in_pre_shift = 4'(pre); in_post_shift = 4'(post); out_ready = ordy;
    #1;
    if (hold_pend) chk(out_valid && out_quotient == hold_q, "R7", out_quotient, hold_q);
    hold_pend = out_valid && !out_ready;
    hold_q = out_quotient;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected output", out_quotient, '0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_quotient == e, t, out_quotient, e);
      end
    end
    if (v && in_ready) begin
      exp_q.push_back(expect_word(x, sg, d));
      tag_q.push_back(tag);
    end
    acc = v && in_ready;
    ov = out_valid;
  endtask

  task automatic send(input logic [WW-1:0] x, input bit sg, input int d, input string tag, input bit rnd);
    bit acc, ov;
    acc = 0;
    while (!acc) begin
      if (rnd && $urandom_range(1, 0) == 0) step(0, x, sg, d, 1'($urandom), tag, acc, ov);
      else step(1, x, sg, d, rnd ? 1'($urandom) : 1'b1, tag, acc, ov);
    end
  endtask

  task automatic drain();
    bit acc, ov;
    int n = 0;
    while ((exp_q.size() != 0 || hold_pend) && n < 100) begin
      step(0, '0, 0, 1, 1, "", acc, ov);
      n++;
    end
    chk(exp_q.size() == 0, "R8 lost result", WW'(exp_q.size()), '0);
  endtask

  function automatic logic [WW-1:0] mk_vec(input int d);
    logic [WW-1:0] v;
    v[0*LW +: LW] = 16'h0000;
    v[1*LW +: LW] = 16'hffff;
    v[2*LW +: LW] = 16'h8000;
    v[3*LW +: LW] = 16'h7fff;
    v[4*LW +: LW] = LW'(d);
    v[5*LW +: LW] = LW'(d - 1);
    v[6*LW +: LW] = LW'($urandom);
    v[7*LW +: LW] = LW'($urandom);
    return v;
  endfunction

  function automatic logic [WW-1:0] rnd_vec();
    logic [WW-1:0] v;
    for (int i = 0; i < WW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    bit acc, ov;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R9 out_valid in reset", WW'(out_valid), '0);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(in_ready, "R9 in_ready after reset", WW'(in_ready), WW'(1));

    step(1, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 0, 7, 1, "R6 data", acc, ov);
    chk(acc, "R6 accept", WW'(acc), WW'(1));
    step(0, '0, 0, 1, 1, "", acc, ov);
    chk(!ov, "R6 not early", WW'(ov), '0);
    step(0, '0, 0, 1, 1, "", acc, ov);
    chk(ov, "R6 valid after second edge", WW'(ov), WW'(1));
    drain();

    send(mk_vec(1), 0, 1, "R4 unsigned d=1", 0);
    send(mk_vec(1), 1, 1, "R4 signed d=1", 0);
    send(128'h8000_7fff_ffff_0000_8000_0001_ffff_8000, 1, 1, "R4 signed extremes", 0);
    drain();

    send(128'hffff_0000_ffff_0000_8000_7fff_8000_7fff, 0, 3, "R3 unsigned", 0);
    send(128'hffff_0000_ffff_0000_8000_7fff_8000_7fff, 1, 3, "R3 signed", 0);
    send(128'h0001_ffff_0001_ffff_ffff_0001_ffff_0001, 1, 2, "R3 signed pairs", 0);
    drain();

    for (int d = 1; d <= 3000; d++) send(mk_vec(d), 0, d, "R1 sweep", 0);
    for (int i = 0; i < 2000; i++) begin
      int d = $urandom_range(65535, 1);
      send((i % 2) ? mk_vec(d) : rnd_vec(), 0, d, "R1 random", 0);
    end
    for (int k = 1; k < 16; k++) send(mk_vec(1 << k), 0, 1 << k, "R1 power of two", 0);
    send(mk_vec(65535), 0, 65535, "R1 max divisor", 0);
    drain();

    for (int d = 1; d <= 3000; d++) send(mk_vec(d), 1, d, "R2 sweep", 0);
    for (int i = 0; i < 2000; i++) begin
      int d = $urandom_range(32767, 1);
      send((i % 2) ? mk_vec(d) : rnd_vec(), 1, d, "R2 random", 0);
    end
    for (int k = 1; k < 15; k++) send(mk_vec(1 << k), 1, 1 << k, "R2 power of two", 0);
    send(mk_vec(32767), 1, 32767, "R2 max divisor", 0);
    drain();

    for (int i = 0; i < 1000; i++) begin
      bit sg = i[0];
      int d = sg ? $urandom_range(32767, 1) : $urandom_range(65535, 1);
      send(rnd_vec(), sg, d, "R5 mode switch", 0);
    end
    drain();

    for (int i = 0; i < 4000; i++) begin
      bit sg = 1'($urandom);
      int d = sg ? $urandom_range(32767, 1) : $urandom_range(65535, 1);
      send(mk_vec(d), sg, d, "R8 stall stream", 1);
    end
    drain();

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule